// File: doc/BRIEF.md
# Serial Byte Transmitter with Fractional Stop Length

This block sends bytes as asynchronous serial frames: one start bit, eight data bits sent least significant bit first, no parity, and a stop period. All timing comes from a one-cycle strobe, `tick_16x`, that pulses sixteen times per bit period. The start bit and every data bit last sixteen strobes. The stop period can be any whole number of strobes, so its length moves in sixteenths of a bit.

It is intended for a repeater that sends received bytes onward on its own clock. The buffer between receiver and transmitter supplies a two-bit rate indication. When bytes arrive faster than they leave, each new frame's stop period is one sixteenth shorter. When they arrive slower, it is one sixteenth longer. When the two sides are balanced, it moves one sixteenth back toward a full bit. This lets the outgoing average rate follow a slightly fast or slow source without a sudden whole-bit jump. A fixed mode sends a 15/16-bit stop on every frame, whatever the rate indication says.

Bytes are taken on a valid/ready handshake. Ready is raised only after the whole stop period has gone out.

Top module: `uart_fracstop_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From that edge, `txd` is 0 for exactly 16 `tick_16x` pulses.
- R3: The eight data bits follow the start bit, least significant bit first. Each data bit lasts exactly 16 tick pulses.
- R4: After reset, a frame sent with a balanced rate indication (`rate_ind` 00) has a stop period of 16 ticks, with `txd` high.
- R5: With `rate_ind` = 01 (source faster) at acceptance, the adaptive stop length drops by one tick, and that frame uses the new value.
- R6: With `rate_ind` = 10 (source slower) at acceptance, the adaptive stop length rises by one tick, and that frame uses the new value.
- R7: The adaptive stop length never goes below 12 or above 20 ticks. A request past either limit leaves it at the limit.
- R8: With `rate_ind` = 00 or 11 at acceptance, the adaptive stop length moves one tick toward 16, or stays at 16.
- R9: With `fixed_short` = 1 at acceptance, the frame's stop period is 15 ticks and the adaptive length is left unchanged. The next adaptive frame continues from the unchanged value.
- R10: `in_ready` is the inverse of `busy`. While a frame is in progress, `in_valid` is ignored. A held `in_valid` starts the next frame only on the edge after the stop period ends.
- R11: `rate_ind` and `fixed_short` are sampled only at acceptance. Changing them during a frame does not alter that frame.
- R12: Frame timing advances only on `tick_16x` pulses. While no pulse arrives, `txd` and `busy` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_16x | input | 1 | One-cycle strobe at sixteen times the bit rate |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Transmitter can take a byte |
| fixed_short | input | 1 | 1: fixed 15-tick stop for this frame |
| rate_ind | input | 2 | 01 source faster, 10 source slower, 00/11 balanced |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
`txd` goes low on the same edge that accepts a byte, with no added pipeline stage. Each later line change happens on the edge where the final tick of a bit or of the stop period is sampled. On that same edge `in_ready` returns, and `busy` falls with it.

The bench model builds the frame as a list of tick-wide line levels at the accepting edge and removes one entry on each ticked edge. Every output is compared half a cycle after each edge, so each output is checked on the cycle it is due. Stop lengths are also measured on their own by counting the tick pulses between acceptance and the return of ready: a frame takes 144 ticks plus its stop length.

// File: rtl/uft_pkg.sv
package uft_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_START = 2'd1,
      PH_DATA  = 2'd2,
      PH_STOP  = 2'd3
   } phase_e;

   localparam logic [1:0] RATE_EVEN = 2'b00;
   localparam logic [1:0] RATE_FAST = 2'b01;
   localparam logic [1:0] RATE_SLOW = 2'b10;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/uft_stop_ctrl.sv
module uft_stop_ctrl #(
   parameter int unsigned CW        = 5,
   parameter int unsigned STOP_MIN  = 12,
   parameter int unsigned STOP_MAX  = 20,
   parameter int unsigned STOP_NOM  = 16,
   parameter int unsigned STOP_FIX  = 15,
   parameter bit          RELAX_NOM = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          fixed_short,
   input  logic [1:0]    rate_ind,
   output logic [CW-1:0] adapt_len,
   output logic [CW-1:0] frame_len
);
   import uft_pkg::*;

   localparam logic [CW-1:0] MIN_V = CW'(STOP_MIN);
   localparam logic [CW-1:0] MAX_V = CW'(STOP_MAX);
   localparam logic [CW-1:0] NOM_V = CW'(STOP_NOM);
   localparam logic [CW-1:0] FIX_V = CW'(STOP_FIX);

   logic [CW-1:0] len_q;
   logic [CW-1:0] even_nxt;
   logic [CW-1:0] adapt_nxt;

   generate
      if (RELAX_NOM) begin : g_relax
         always_comb begin
            if (len_q > NOM_V)      even_nxt = len_q - 1'b1;
            else if (len_q < NOM_V) even_nxt = len_q + 1'b1;
            else                    even_nxt = len_q;
         end
      end else begin : g_hold
         always_comb even_nxt = len_q;
      end
   endgenerate

   always_comb begin
      case (rate_ind)
         RATE_FAST: adapt_nxt = (len_q > MIN_V) ? len_q - 1'b1 : MIN_V;
         RATE_SLOW: adapt_nxt = (len_q < MAX_V) ? len_q + 1'b1 : MAX_V;
         default:   adapt_nxt = even_nxt;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    len_q <= NOM_V;
      else if (load && !fixed_short) len_q <= adapt_nxt;
   end

   assign adapt_len = len_q;
   assign frame_len = fixed_short ? FIX_V : adapt_nxt;
endmodule

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
   parameter int unsigned CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          tick,
   input  logic [CW-1:0] limit,
   output logic          last
);
   logic [CW-1:0] cnt_q;

   assign last = run && tick && (cnt_q == limit - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || last) cnt_q <= '0;
      else if (tick)         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/uft_shifter.sv
module uft_shifter #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          shift,
   input  logic [DW-1:0] din,
   output logic          bit_out
);
   logic [DW-1:0] sreg_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     sreg_q <= '1;
      else if (load)  sreg_q <= din;
      else if (shift) sreg_q <= {1'b1, sreg_q[DW-1:1]};
   end

   assign bit_out = sreg_q[0];
endmodule

// File: rtl/uart_fracstop_tx.sv
module uart_fracstop_tx #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned BIT_TICKS = 16,
   parameter int unsigned STOP_MIN  = 12,
   parameter int unsigned STOP_MAX  = 20,
   parameter int unsigned STOP_NOM  = 16,
   parameter int unsigned STOP_FIX  = 15,
   parameter bit          RELAX_NOM = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_16x,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              fixed_short,
   input  logic [1:0]        rate_ind,
   output logic              txd,
   output logic              busy
);
   import uft_pkg::*;

   localparam int unsigned CNT_MAX = max_u(BIT_TICKS, STOP_MAX);
   localparam int unsigned CW      = $clog2(CNT_MAX + 1);
   localparam int unsigned IDX_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
   localparam logic [CW-1:0]    BIT_V    = CW'(BIT_TICKS);
   localparam logic [CW-1:0]    NOM_V    = CW'(STOP_NOM);

   generate
      if (DATA_W < 2)            begin : g_bad_dw   $error("DATA_W must be at least 2"); end
      if (BIT_TICKS < 2)         begin : g_bad_bt   $error("BIT_TICKS must be at least 2"); end
      if (STOP_MIN < 1)          begin : g_bad_min  $error("STOP_MIN must be at least 1"); end
      if (STOP_MIN > STOP_NOM)   begin : g_bad_lo   $error("STOP_NOM below STOP_MIN"); end
      if (STOP_NOM > STOP_MAX)   begin : g_bad_hi   $error("STOP_NOM above STOP_MAX"); end
      if (STOP_FIX < STOP_MIN || STOP_FIX > STOP_MAX)
                                 begin : g_bad_fix  $error("STOP_FIX outside limits"); end
   endgenerate

   phase_e           phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [CW-1:0]    fstop_q;
   logic [CW-1:0]    frame_len;
   logic [CW-1:0]    adapt_len;
   logic [CW-1:0]    limit;
   logic             accept;
   logic             last;
   logic             data_bit;

   assign in_ready = (phase_q == PH_IDLE);
   assign busy     = !in_ready;
   assign accept   = in_valid && in_ready;
   assign limit    = (phase_q == PH_STOP) ? fstop_q : BIT_V;

   uft_stop_ctrl #(
      .CW(CW), .STOP_MIN(STOP_MIN), .STOP_MAX(STOP_MAX),
      .STOP_NOM(STOP_NOM), .STOP_FIX(STOP_FIX), .RELAX_NOM(RELAX_NOM)
   ) u_stop_ctrl (
      .clk(clk), .rst_n(rst_n), .load(accept), .fixed_short(fixed_short),
      .rate_ind(rate_ind), .adapt_len(adapt_len), .frame_len(frame_len)
   );

   uft_bit_timer #(.CW(CW)) u_bit_timer (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick_16x),
      .limit(limit), .last(last)
   );

   uft_shifter #(.DW(DATA_W)) u_shifter (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .shift((phase_q == PH_DATA) && last),
      .din(in_data), .bit_out(data_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         idx_q   <= '0;
         fstop_q <= NOM_V;
      end else begin
         case (phase_q)
            PH_IDLE: if (accept) begin
               phase_q <= PH_START;
               fstop_q <= frame_len;
            end
            PH_START: if (last) begin
               phase_q <= PH_DATA;
               idx_q   <= '0;
            end
            PH_DATA: if (last) begin
               if (idx_q == IDX_LAST) phase_q <= PH_STOP;
               else                   idx_q   <= idx_q + 1'b1;
            end
            default: if (last) phase_q <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      case (phase_q)
         PH_START: txd = 1'b0;
         PH_DATA:  txd = data_bit;
         default:  txd = 1'b1;
      endcase
   end
endmodule

// File: rtl/uart_fracstop_tx_chk.sv
module uart_fracstop_tx_chk #(
   parameter int unsigned CW       = 5,
   parameter int unsigned STOP_MIN = 12,
   parameter int unsigned STOP_MAX = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_16x,
   input logic          in_valid,
   input logic          in_ready,
   input logic          fixed_short,
   input logic          txd,
   input logic          busy,
   input logic [CW-1:0] adapt_len
);
   logic acc;
   assign acc = in_valid && in_ready;

   p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   p_ready_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready != busy);

   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (!txd && busy));

   p_no_tick_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick_16x) |=> ($stable(txd) && busy));

   p_len_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adapt_len >= CW'(STOP_MIN)) && (adapt_len <= CW'(STOP_MAX)));

   p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> ((adapt_len == $past(adapt_len)) ||
               ({1'b0, adapt_len} == {1'b0, $past(adapt_len)} + 1'b1) ||
               ({1'b0, adapt_len} + 1'b1 == {1'b0, $past(adapt_len)})));

   p_frame_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(adapt_len));

   p_fixed_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && fixed_short) |=> $stable(adapt_len));
endmodule

bind uart_fracstop_tx uart_fracstop_tx_chk #(
   .CW(CW), .STOP_MIN(STOP_MIN), .STOP_MAX(STOP_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .in_valid(in_valid),
   .in_ready(in_ready), .fixed_short(fixed_short), .txd(txd), .busy(busy),
   .adapt_len(adapt_len)
);

// File: tb/uart_fracstop_tx_bench.sv
`timescale 1ns/1ps
module uart_fracstop_tx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_16x = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       fixed_short = 1'b0;
   logic [1:0] rate_ind = 2'b00;
   logic       txd;
   logic       busy;

   int checks = 0;
   int fails  = 0;
   int tick_en = 1;
   int tdiv = 0;
   int tick_count = 0;
   int model_len = 16;
   bit line_q[$];

   always #2 clk = ~clk;

   uart_fracstop_tx u_uart_fracstop_tx (
      .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .fixed_short(fixed_short),
      .rate_ind(rate_ind), .txd(txd), .busy(busy)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // strobe generator, one pulse every 3 clocks while enabled
   always @(negedge clk) begin
      if (tick_en == 0) begin
         tick_16x <= 1'b0;
      end else begin
         tdiv = (tdiv + 1) % 3;
         tick_16x <= (tdiv == 0);
      end
   end

   // behavioural reference: the frame as a list of tick-wide line levels
   always @(posedge clk) begin
      if (!rst_n) begin
         line_q.delete();
         model_len = 16;
      end else if (line_q.size() == 0 && in_valid) begin
         int stop;
         if (!fixed_short) begin
            if (rate_ind == 2'b01)      model_len = (model_len > 12) ? model_len - 1 : 12;
            else if (rate_ind == 2'b10) model_len = (model_len < 20) ? model_len + 1 : 20;
            else if (model_len > 16)    model_len = model_len - 1;
            else if (model_len < 16)    model_len = model_len + 1;
         end
         stop = fixed_short ? 15 : model_len;
         for (int i = 0; i < 16; i++) line_q.push_back(1'b0);
         for (int b = 0; b < 8; b++)
            for (int i = 0; i < 16; i++) line_q.push_back(in_data[b]);
         for (int i = 0; i < stop; i++) line_q.push_back(1'b1);
      end else if (line_q.size() != 0 && tick_16x) begin
         void'(line_q.pop_front());
      end
      if (rst_n && busy && tick_16x) tick_count++;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit exp_txd;
         exp_txd = (line_q.size() != 0) ? line_q[0] : 1'b1;
         chk(txd == exp_txd, "R3 line level", txd, exp_txd);
         chk(in_ready == (line_q.size() == 0), "R10 ready", in_ready, line_q.size() == 0);
         chk(busy == (line_q.size() != 0), "R10 busy", busy, line_q.size() != 0);
      end
   end

   // send one frame; after acceptance scramble the mode inputs (R11)
   task automatic send(input logic [7:0] d, input logic [1:0] r, input logic fx,
                       input int exp_stop, input string tag);
      while (!in_ready) @(negedge clk);
      in_data = d; rate_ind = r; fixed_short = fx; in_valid = 1'b1;
      @(posedge clk);
      tick_count = 0;
      @(negedge clk);
      in_valid = 1'b0; rate_ind = ~r; fixed_short = ~fx; in_data = ~d;
      while (!in_ready) @(negedge clk);
      chk(tick_count == 144 + exp_stop, tag, tick_count, 144 + exp_stop);
      rate_ind = 2'b00; fixed_short = 1'b0;
   endtask

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R1 idle line", txd, 1);
      chk(in_ready == 1'b1, "R1 idle ready", in_ready, 1);
      chk(busy == 1'b0, "R1 idle busy", busy, 0);

      send(8'hA5, 2'b00, 1'b0, 16, "R4 nominal stop");
      send(8'h3C, 2'b01, 1'b0, 15, "R5 shorten 15");
      send(8'h01, 2'b01, 1'b0, 14, "R5 shorten 14");
      send(8'h80, 2'b01, 1'b0, 13, "R5 shorten 13");
      send(8'hFF, 2'b01, 1'b0, 12, "R5 shorten 12");
      send(8'h00, 2'b01, 1'b0, 12, "R7 low clamp");
      send(8'h5A, 2'b01, 1'b1, 15, "R9 fixed short");
      send(8'hC3, 2'b00, 1'b0, 13, "R9 adaptive resumes, R8 relax up");
      send(8'h96, 2'b00, 1'b0, 14, "R8 relax up");
      send(8'h11, 2'b10, 1'b0, 15, "R6 lengthen 15");
      send(8'h22, 2'b10, 1'b0, 16, "R6 lengthen 16");
      send(8'h44, 2'b10, 1'b0, 17, "R6 lengthen 17");
      send(8'h88, 2'b10, 1'b0, 18, "R6 lengthen 18");
      send(8'h7E, 2'b10, 1'b0, 19, "R6 lengthen 19");
      send(8'hE7, 2'b10, 1'b0, 20, "R6 lengthen 20");
      send(8'h18, 2'b10, 1'b0, 20, "R7 high clamp");
      send(8'h69, 2'b00, 1'b0, 19, "R8 relax down");
      send(8'hB4, 2'b11, 1'b0, 18, "R8 code 11 balanced");
      send(8'h2D, 2'b10, 1'b1, 15, "R11 fixed with slow request");
      send(8'hD2, 2'b00, 1'b0, 17, "R11 adaptive unaffected");

      // R10: valid held high across two frames
      in_data = 8'h4B; rate_ind = 2'b00; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_data = 8'hB2;
      while (!in_ready) @(negedge clk);
      chk(in_ready == 1'b1, "R10 ready after stop", in_ready, 1);
      @(negedge clk);
      chk(busy == 1'b1, "R10 held valid starts next frame", busy, 1);
      in_valid = 1'b0;
      while (!in_ready) @(negedge clk);

      // R12: tick gap in the middle of a frame
      in_data = 8'h0F; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (200) @(negedge clk);
      tick_en = 0;
      @(negedge clk);
      begin
         logic held;
         held = txd;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk(txd == held && busy, "R12 hold without ticks", txd, held);
         end
      end
      tick_en = 1;
      while (!in_ready) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(txd == 1'b1, "R1 idle after frames", txd, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule